// File: doc/BRIEF.md
# Sample Slip Timing Compensator

This block sits in a receiver's sample stream after frame acquisition and removes the slow timing walk caused by a fixed mismatch between the transmitter and receiver sampling clocks. It leaves the sampling clock alone. Instead, at scheduled points it either repeats one sample or discards one. Every later sample then moves by one sample time against the receiver's reference sequences. No phase is tracked during the packet. The schedule comes entirely from an offset estimate taken once, during the preamble.

The estimator supplies a 4-bit offset index and a direction bit. Index k stands for an offset of k × 4 ppm, so the 16 steps cover 0 to 60 ppm. The direction bit set means the receiver clock runs fast, so one sample is discarded at each correction. Cleared means it runs slow, so one sample is repeated. The block latches index and direction while the enable is low and freezes them when the enable rises at packet start.

A table computed at elaboration gives the correction interval for each index. Each entry is 16 bits and counts chips of four samples. The table base is 62500 chips, which is 250000 samples and one full sample of drift at 4 ppm. Input samples arrive at most every other clock, which leaves the spare cycle needed for a repeated sample.

Top module: `slip_comp`

## Requirements
- R1: While reset is held and in the first cycle after release, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: While `en_i` is low, each input sample appears on the output exactly one clock later, unchanged, and no correction is made.
- R3: With latched index 0, samples pass through with one clock of latency even while `en_i` is high.
- R4: Index and direction are latched on every clock where `en_i` is low. Changes to `idx_i` or `dir_i` while `en_i` is high have no effect on the schedule.
- R5: For latched index k ≥ 1, the correction interval is (BASE_UNITS / k) × 4 samples, with integer division and BASE_UNITS = 62500 by default. Each table entry fits in 16 bits.
- R6: The first correction after `en_i` rises applies to the accepted input sample whose 1-based count equals half the interval.
- R7: Each later correction applies to the sample that comes a full interval after the previous corrected sample.
- R8: With `dir_i` = 1, a corrected sample produces no output cycle.
- R9: With `dir_i` = 0, a corrected sample is output on two consecutive cycles with the same data, starting one clock after it is accepted.
- R10: Over a packet of N samples with interval F, the number of corrections is 0 if N < F/2 and otherwise 1 + (N − F/2) / F. Output count minus input count equals that number for a repeat and minus that number for a discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | High for the packet; low re-arms the schedule and latches the offset |
| idx_i | input | IDX_W (4) | Offset index, k × 4 ppm |
| dir_i | input | 1 | 1 = receiver clock fast (discard), 0 = slow (repeat) |
| in_valid_i | input | 1 | Input sample strobe, at most every other clock |
| in_data_i | input | DATA_W (12) | Input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | DATA_W (12) | Output sample |

## Verification
At the default base, corrections are tens of thousands of samples apart, and a full sweep of indices cannot fit in a short run. The bench therefore overrides BASE_UNITS with a small value so that many corrections occur in each packet at every tested index. The exact sample that is discarded or repeated can then be recovered from breaks in the output's counting data pattern. The run that is hardest to reach changes `idx_i` in the middle of an enabled packet: only the count of corrections at the end of that packet shows whether the frozen configuration held.

// File: rtl/slipc_pkg.sv
package slipc_pkg;

  // Correction interval, in chips, for offset step idx; 0 disables correction.
  function automatic int unsigned interval_units(input int unsigned idx,
                                                 input int unsigned base);
    if (idx == 0) return 0;
    return base / idx;
  endfunction

  // Samples to the first correction given an entry (chips) and samples per chip.
  function automatic int unsigned first_samples(input int unsigned entry,
                                                input int unsigned per_chip);
    return (entry * per_chip) / 2;
  endfunction

endpackage

// File: rtl/slip_lut.sv
module slip_lut #(
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned ENTRY_W    = 16,
  parameter int unsigned BASE_UNITS = 62500
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ENTRY_W-1:0] entry_o
);
  localparam int unsigned STEPS = 1 << IDX_W;

  logic [ENTRY_W-1:0] table_w [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign table_w[g] = ENTRY_W'(slipc_pkg::interval_units(g, BASE_UNITS));
  end

  assign entry_o = table_w[idx_i];
endmodule

// File: rtl/slip_sched.sv
module slip_sched #(
  parameter int unsigned ENTRY_W  = 16,
  parameter int unsigned PER_CHIP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               in_valid_i,
  input  logic               dir_i,
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               fire_ins_o,
  output logic               fire_drop_o
);
  localparam int unsigned CNT_W = ENTRY_W + $clog2(PER_CHIP) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             first_q;
  logic [CNT_W-1:0] full_w;
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] target_w;
  logic             active_w;
  logic             hit_w;

  assign full_w   = CNT_W'(entry_i) * CNT_W'(PER_CHIP);
  assign half_w   = full_w >> 1;
  assign target_w = first_q ? half_w : full_w;
  assign active_w = en_i && (entry_i != '0);
  assign hit_w    = active_w && in_valid_i && ((cnt_q + CNT_W'(1)) == target_w);

  assign fire_drop_o = hit_w && dir_i;
  assign fire_ins_o  = hit_w && !dir_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (active_w && in_valid_i) begin
      if (hit_w) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/slip_emit.sv
module slip_emit #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              fire_ins_i,
  input  logic              fire_drop_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              vld_q;
  logic [DATA_W-1:0] hold_q;
  logic              again_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      hold_q  <= '0;
      again_q <= 1'b0;
    end else if (in_valid_i) begin
      hold_q  <= in_data_i;
      vld_q   <= !fire_drop_i;
      again_q <= fire_ins_i;
    end else if (again_q) begin
      vld_q   <= 1'b1;
      again_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = hold_q;
endmodule

// File: rtl/slip_comp.sv
module slip_comp #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned ENTRY_W    = 16,
  parameter int unsigned PER_CHIP   = 4,
  parameter int unsigned BASE_UNITS = 62500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              dir_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [IDX_W-1:0]   cfg_idx;
  logic               cfg_dir;
  logic [ENTRY_W-1:0] entry_w;
  logic               fire_ins;
  logic               fire_drop;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_idx <= '0;
      cfg_dir <= 1'b0;
    end else if (!en_i) begin
      cfg_idx <= idx_i;
      cfg_dir <= dir_i;
    end
  end

  slip_lut #(
    .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .BASE_UNITS(BASE_UNITS)
  ) lut_i (
    .idx_i(cfg_idx), .entry_o(entry_w)
  );

  slip_sched #(
    .ENTRY_W(ENTRY_W), .PER_CHIP(PER_CHIP)
  ) sched_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .in_valid_i(in_valid_i),
    .dir_i(cfg_dir), .entry_i(entry_w),
    .fire_ins_o(fire_ins), .fire_drop_o(fire_drop)
  );

  slip_emit #(
    .DATA_W(DATA_W)
  ) emit_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .fire_ins_i(fire_ins), .fire_drop_i(fire_drop),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );
endmodule

// File: rtl/slip_comp_chk.sv
module slip_comp_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic              cfg_dir,
  input logic              fire_ins,
  input logic              fire_drop
);
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_drop |=> !out_valid_o); // R8

  AST_INS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_ins |=> (out_valid_o && out_data_o == $past(in_data_i))); // R9

  AST_INS_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire_ins, 2) |-> (out_valid_o && $stable(out_data_o))); // R9

  AST_PASS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !en_i) |=> (out_valid_o && out_data_o == $past(in_data_i))); // R2

  AST_IDLE_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(fire_ins || fire_drop)); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> ($stable(cfg_idx) && $stable(cfg_dir))); // R4

  AST_IDX0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_idx == '0) |-> !(fire_ins || fire_drop)); // R3
endmodule

bind slip_comp slip_comp_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .in_valid_i(in_valid_i),
  .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .cfg_idx(cfg_idx), .cfg_dir(cfg_dir), .fire_ins(fire_ins), .fire_drop(fire_drop)
);

// File: tb/slip_comp_tb_top.sv
module slip_comp_tb_top;
  localparam int DW      = 12;
  localparam int TB_BASE = 250;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [3:0]    idx = '0;
  logic          dir = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  slip_comp #(.DATA_W(DW), .BASE_UNITS(TB_BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .idx_i(idx), .dir_i(dir),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  // Behavioural reference: integer sample counts and a target per packet.
  int    m_v, m_d, m_pend, m_cnt, m_first, m_idx, m_dir;
  string m_tag = "R1";

  always @(posedge clk) begin
    int nv, nd, full, tgt;
    if (!rst_n) begin
      m_v = 0; m_d = 0; m_pend = 0; m_cnt = 0; m_first = 1; m_idx = 0; m_dir = 0;
      m_tag = "R1";
    end else begin
      nv = 0; nd = m_d;
      if (m_pend != 0) begin nv = 1; m_pend = 0; m_tag = "R9"; end
      if (in_valid) begin
        nv = 1; nd = int'(in_data);
        m_tag = en ? (m_idx == 0 ? "R3" : "R5") : "R2";
        if (en && m_idx != 0) begin
          m_cnt++;
          full = (TB_BASE / m_idx) * 4;
          tgt  = (m_first != 0) ? full / 2 : full;
          if (m_cnt == tgt) begin
            m_tag = (m_first != 0) ? "R6/R8/R9" : "R7/R8/R9";
            m_cnt = 0; m_first = 0;
            if (m_dir != 0) nv = 0; else m_pend = 1;
          end
        end
      end
      if (!en) begin m_idx = int'(idx); m_dir = int'(dir); m_cnt = 0; m_first = 1; end
      m_v = nv; m_d = nd;
    end
  end

  // Output monitor: every-cycle compare plus slip detection on counting data.
  int mon_prev, mon_out, mon_ins, mon_drop, mon_first;

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (int'(out_valid) != m_v || int'(out_data) != m_d) begin
        n_fail++;
        $display("FAIL %s cycle %0d: valid/data %0d/%0d expected %0d/%0d",
                 m_tag, cycles, out_valid, out_data, m_v, m_d);
      end
      if (out_valid) begin
        mon_out++;
        if (int'(out_data) == mon_prev) begin
          mon_ins++;
          if (mon_first < 0) mon_first = int'(out_data);
        end else if (int'(out_data) == mon_prev + 2) begin
          mon_drop++;
          if (mon_first < 0) mon_first = int'(out_data) - 1;
        end
        mon_prev = int'(out_data);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      n_fail++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int v, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(v);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // One packet: latch offset with enable low, stream n samples, check totals.
  task automatic packet(input int k, input int d, input int n, input int use_en,
                        input int swap_idx);
    int full, half, exp_n, n_in;
    @(negedge clk);
    en = 1'b0; idx = 4'(k); dir = d[0];
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    mon_prev = 0; mon_out = 0; mon_ins = 0; mon_drop = 0; mon_first = -1;
    n_in = 0;
    @(negedge clk);
    en = use_en[0];
    for (int i = 1; i <= n; i++) begin
      if (swap_idx >= 0 && i == n / 2) begin idx = 4'(swap_idx); dir = ~dir; end
      send(i, (i % 7 == 0) ? 2 : 0);
      n_in++;
    end
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    if (use_en == 0 || k == 0) begin
      exp_n = 0;
      full = 0;
    end else begin
      full = (TB_BASE / k) * 4;
      half = full / 2;
      exp_n = (n < half) ? 0 : 1 + (n - half) / full;
    end
    check("R10 corrections", mon_ins + mon_drop, exp_n);
    check("R8 discards", mon_drop, (d != 0) ? exp_n : 0);
    check("R9 repeats", mon_ins, (d != 0) ? 0 : exp_n);
    check("R10 net out minus in", mon_out - n_in, (d != 0) ? -exp_n : exp_n);
    if (exp_n > 0) check("R6 first corrected sample", mon_first, full / 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 data after release", int'(out_data), 0);

    packet(5, 1, 400, 0, -1);    // R2: enable low, offset ignored
    packet(0, 1, 300, 1, -1);    // R3: index 0 passes through
    packet(1, 1, 2000, 1, -1);   // R5 R7: slowest step, discards
    packet(1, 0, 2000, 1, -1);   // R9: slowest step, repeats
    packet(3, 1, 1500, 1, -1);   // R7
    packet(7, 0, 1000, 1, -1);   // R7 R9
    packet(15, 1, 1000, 1, -1);  // R5: fastest step
    packet(15, 0, 600, 1, -1);   // R9
    packet(5, 0, 1200, 1, 15);   // R4: mid-packet index change ignored
    packet(9, 1, 20, 1, -1);     // R10: packet shorter than half interval

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule